// File: doc/BRIEF.md
# Channel Fault Supervisor

This block watches one switching power channel and decides, once per switching period, whether the channel keeps running, goes through a discharge-and-restart cycle, or is shut down and held off. It does not look at analog quantities. It receives digital flags from external comparators for three conditions: excess current, low output and high output. It also receives a strobe that marks the start of each switching period, an enable level, a flag that says the soft-start ramp has finished, and a supply-good level.

Each fault kind keeps its own count of consecutive flagged periods, and each leads to a different action:
- A sustained current fault shuts the channel down with both gates released to high impedance.
- A sustained low output discharges the soft-start node for a fixed number of periods and then lets a fresh ramp begin.
- A high output first forces the low-side switch on. If the condition persists, the channel is shut down with its gates released, and the soft-start charge is left in place.

A shut-down channel stays off until its enable drops or the supply-good level falls. A system with two channels uses one instance per channel, so the channels share no state.

Top module: `chan_fault_sup`

## Requirements
- R1: While reset is asserted, and in the cycle after reset when enable is low, `gate_hiz`, `ss_discharge` and `force_low` are all 0.
- R2: When `oc_flag` is 1 on OC_STREAK (default 32) consecutive strobes, `gate_hiz` becomes 1 at the clock edge that samples the last of those strobes. After 31 such strobes it is still 0.
- R3: `pulse_cut` equals `oc_flag` whenever the channel is running, whatever the value of `ss_done`. The current-fault count also advances while `ss_done` is 0.
- R4: Once `gate_hiz` is 1 it stays 1 while `en_in` and `por_ok` are both 1. A single clock with `en_in` at 0 or `por_ok` at 0 clears it, and the channel runs again once both return to 1.
- R5: When `uv_flag` is 1 on UV_STREAK (default 8) consecutive strobes, `ss_discharge` becomes 1 at that edge. It stays 1 for HICCUP_LEN (default 4) further strobes, drops at the edge of the last of them, and the channel then runs again.
- R6: While `ss_done` is 0, `ov_flag` has no effect: `force_low` stays 0 and no high-output count builds up.
- R7: With `ss_done` at 1, a strobe that sees `ov_flag` at 1 sets `force_low` to 1. A later strobe that sees `ov_flag` at 0 returns it to 0.
- R8: When `ov_flag` is 1 with `ss_done` at 1 on OV_STREAK (default 32) consecutive strobes, `gate_hiz` becomes 1, and `force_low` and `ss_discharge` are both 0.
- R9: A strobe at which a fault's flag is 0 sets that fault's consecutive count back to zero.
- R10: Fault flags are read only in clock cycles where `cyc_strobe` is 1. Flags raised between strobes have no effect.
- R11: When the current-fault shutdown and the low-output restart are both due at the same strobe, the shutdown wins: `gate_hiz` becomes 1 and `ss_discharge` stays 0.
- R12: Fault flags seen during the discharge period are not counted. Every count starts from zero when the channel runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_strobe | input | 1 | One-clock pulse at the start of each switching period |
| en_in | input | 1 | Channel enable: soft-start node above its enable threshold |
| por_ok | input | 1 | Supply above its power-on threshold |
| ss_done | input | 1 | Soft-start ramp has reached its end |
| oc_flag | input | 1 | Excess-current comparator result |
| uv_flag | input | 1 | Low-output comparator result |
| ov_flag | input | 1 | High-output comparator result |
| ss_discharge | output | 1 | Request to discharge the soft-start node |
| force_low | output | 1 | Request to hold the low-side switch on |
| gate_hiz | output | 1 | Request to release both gate drivers to high impedance |
| pulse_cut | output | 1 | Request to end the present high-side pulse early |

## Verification
The bench builds the block with its default parameters: streak lengths of 32, 8 and 32 and a discharge period of 4 strobes. It issues a strobe every 4 clocks, so full-length streaks are reached within a few hundred clocks. This lets the bench drive the exact boundary between 31 and 32 flagged periods, a streak broken by one clean period, and a current-fault streak and a low-output streak that complete at the same strobe. It also checks that strobes arriving during the discharge period do not count toward a later current-fault shutdown.

// File: rtl/chan_fault_pkg.sv
// Package: shared state type and fault indices for the channel fault supervisor.
// Assumes: a single clock domain; used by every module of the block.
package chan_fault_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_HICCUP = 2'd2,
        ST_LATCH  = 2'd3
    } sup_state_e;

    localparam int NUM_FAULTS = 3;
    localparam int FLT_OC     = 0;
    localparam int FLT_UV     = 1;
    localparam int FLT_OV     = 2;

endpackage

// File: rtl/streak_counter.sv
// streak_counter: counts consecutive strobes on which a condition is true.
// Raises hit, combinationally, on the strobe that completes LIMIT in a row.
// Assumes: strobe is a single-clock pulse; clr holds the count at zero.
module streak_counter #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic strobe,
    input  logic cond,
    output logic hit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Completion of the streak at this strobe.
    always_comb hit = strobe && cond && (cnt == LAST);

    // Advance on a flagged strobe, restart on a clean strobe or on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (strobe) begin
            if (cond && !hit) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    // R9: a clean strobe always leaves the count at zero.
    a_r9_clean_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !cond) |=> (cnt == '0));

    // R2: the count never reaches the limit itself.
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= LAST));

endmodule

// File: rtl/hiccup_timer.sv
// hiccup_timer: measures the discharge period in strobes.
// Raises done on the LEN-th strobe seen while active.
// Assumes: active is held for the whole discharge period.
module hiccup_timer #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic strobe,
    output logic done
);
    localparam int TW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [TW-1:0] LAST = TW'(LEN - 1);

    logic [TW-1:0] cnt;

    // End of the discharge period.
    always_comb done = active && strobe && (cnt == LAST);

    // Count strobes only while discharging.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt <= '0;
        end else if (strobe && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: the timer is idle outside the discharge period.
    a_r5_idle_when_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |=> (cnt == '0));

endmodule

// File: rtl/sup_fsm.sv
// sup_fsm: channel state machine (off, run, discharge-restart, latched off).
// Consumes the streak hits and the timer end; drives the output requests.
// Assumes: a shutdown takes priority over a restart at the same strobe.
module sup_fsm
    import chan_fault_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_in,
    input  logic       por_ok,
    input  logic       strobe,
    input  logic       ov_seen,
    input  logic       oc_hit,
    input  logic       uv_hit,
    input  logic       ov_hit,
    input  logic       hic_done,
    output logic       running,
    output logic       in_hiccup,
    output logic       latched,
    output logic       force_low
);
    sup_state_e state, nxt;
    logic       live;

    // The channel is allowed on only with enable and supply both good.
    always_comb live = en_in && por_ok;

    // Next-state selection.
    always_comb begin
        nxt = state;
        if (!live) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:    nxt = ST_RUN;
                ST_RUN: begin
                    if (oc_hit || ov_hit) begin
                        nxt = ST_LATCH;
                    end else if (uv_hit) begin
                        nxt = ST_HICCUP;
                    end
                end
                ST_HICCUP: if (hic_done) nxt = ST_RUN;
                ST_LATCH:  nxt = ST_LATCH;
                default:   nxt = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Low-side hold: refreshed on every strobe while running, dropped on leaving run.
    always_ff @(posedge clk) begin
        if (!rst_n || (nxt != ST_RUN)) begin
            force_low <= 1'b0;
        end else if (strobe && (state == ST_RUN)) begin
            force_low <= ov_seen;
        end
    end

    // Output decode from the state.
    always_comb begin
        running   = (state == ST_RUN);
        in_hiccup = (state == ST_HICCUP);
        latched   = (state == ST_LATCH);
    end

    // R4: dropping enable sends the channel off at the next edge.
    a_r4_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_in || !por_ok) |=> (state == ST_OFF));

    // R4: a latched channel stays latched while enable and supply hold.
    a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && live) |=> (state == ST_LATCH));

    // R11: a shutdown due at the same strobe as a restart wins.
    a_r11_latch_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && live && oc_hit && uv_hit) |=> (state == ST_LATCH));

    // R6: a strobe before the ramp has finished leaves the low side released.
    a_r6_ov_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && strobe && !ov_seen) |=> !force_low);

endmodule

// File: rtl/chan_fault_sup.sv
// chan_fault_sup: per-channel fault supervisor top.
// Three streak counters (current, low output, armed high output), a discharge
// timer and the state machine. Assumes the flags are already digital and
// stable around the strobe; one instance is used per channel.
module chan_fault_sup
    import chan_fault_pkg::*;
#(
    parameter int OC_STREAK  = 32,
    parameter int UV_STREAK  = 8,
    parameter int OV_STREAK  = 32,
    parameter int HICCUP_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_strobe,
    input  logic en_in,
    input  logic por_ok,
    input  logic ss_done,
    input  logic oc_flag,
    input  logic uv_flag,
    input  logic ov_flag,
    output logic ss_discharge,
    output logic force_low,
    output logic gate_hiz,
    output logic pulse_cut
);
    logic [NUM_FAULTS-1:0] cond;
    logic [NUM_FAULTS-1:0] hit;
    logic                  running;
    logic                  in_hiccup;
    logic                  latched;
    logic                  hic_done;
    logic                  cnt_clr;

    // Condition per fault; high output counts only once the ramp is done.
    always_comb begin
        cond[FLT_OC] = oc_flag;
        cond[FLT_UV] = uv_flag;
        cond[FLT_OV] = ov_flag && ss_done;
        cnt_clr      = !running;
    end

    // One streak counter per fault kind, each with its own length.
    for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_streak
        localparam int LIM = (g == FLT_OC) ? OC_STREAK :
                             ((g == FLT_UV) ? UV_STREAK : OV_STREAK);
        streak_counter #(.LIMIT(LIM)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (cnt_clr),
            .strobe (cyc_strobe),
            .cond   (cond[g]),
            .hit    (hit[g])
        );
    end

    hiccup_timer #(.LEN(HICCUP_LEN)) u_hic (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (in_hiccup),
        .strobe (cyc_strobe),
        .done   (hic_done)
    );

    sup_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_in     (en_in),
        .por_ok    (por_ok),
        .strobe    (cyc_strobe),
        .ov_seen   (cond[FLT_OV]),
        .oc_hit    (hit[FLT_OC]),
        .uv_hit    (hit[FLT_UV]),
        .ov_hit    (hit[FLT_OV]),
        .hic_done  (hic_done),
        .running   (running),
        .in_hiccup (in_hiccup),
        .latched   (latched),
        .force_low (force_low)
    );

    // Output requests.
    always_comb begin
        ss_discharge = in_hiccup;
        gate_hiz     = latched;
        pulse_cut    = running && oc_flag;
    end

    // R8: a released gate pair excludes the other two requests.
    a_r8_hiz_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        gate_hiz |-> (!force_low && !ss_discharge));

    // R12: the discharge period always starts from a running channel.
    a_r12_hiccup_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_discharge) |-> $past(running));

endmodule

// File: tb/chan_fault_sup_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected outputs after each strobe,
// and the monitor pops and compares them one clock after the strobe edge.
module chan_fault_sup_test;

    localparam int GAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_strobe = 1'b0;
    logic en_in = 1'b0;
    logic por_ok = 1'b1;
    logic ss_done = 1'b0;
    logic oc_flag = 1'b0;
    logic uv_flag = 1'b0;
    logic ov_flag = 1'b0;
    logic ss_discharge, force_low, gate_hiz, pulse_cut;
    logic noise = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  hiz;
        logic  dis;
        logic  fl;
        string req;
    } exp_t;

    exp_t exp_q[$];
    event smp;

    chan_fault_sup uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_strobe   (cyc_strobe),
        .en_in        (en_in),
        .por_ok       (por_ok),
        .ss_done      (ss_done),
        .oc_flag      (oc_flag),
        .uv_flag      (uv_flag),
        .ov_flag      (ov_flag),
        .ss_discharge (ss_discharge),
        .force_low    (force_low),
        .gate_hiz     (gate_hiz),
        .pulse_cut    (pulse_cut)
    );

    always #10 clk = ~clk;

    task automatic check1(input string req, input logic got, input logic want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, want);
        end
    endtask

    // One switching period: a strobe with the given flags, then quiet clocks.
    task automatic period(input logic oc, input logic uv, input logic ov,
                          input logic ssd, input logic e_hiz, input logic e_dis,
                          input logic e_fl, input string req);
        exp_t e;
        @(negedge clk);
        oc_flag = oc; uv_flag = uv; ov_flag = ov; ss_done = ssd;
        cyc_strobe = 1'b1;
        @(negedge clk);
        cyc_strobe = 1'b0;
        oc_flag = noise; uv_flag = noise; ov_flag = 1'b0;
        e.hiz = e_hiz; e.dis = e_dis; e.fl = e_fl; e.req = req;
        exp_q.push_back(e);
        ->smp;
        repeat (GAP - 2) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk);
        en_in = 1'b0;
        @(negedge clk);
        en_in = 1'b1;
        @(negedge clk);
    endtask

    // Monitor: compares the registered outputs with the oldest expectation.
    initial begin
        forever begin
            exp_t e;
            @(smp);
            e = exp_q.pop_front();
            checks++;
            if (gate_hiz !== e.hiz || ss_discharge !== e.dis || force_low !== e.fl) begin
                errors++;
                $display("FAIL %s: hiz/dis/fl got %b%b%b expected %b%b%b", e.req,
                         gate_hiz, ss_discharge, force_low, e.hiz, e.dis, e.fl);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs idle in reset and right after it with enable low
        repeat (3) @(negedge clk);
        check1("R1 hiz in reset", gate_hiz, 1'b0);
        check1("R1 dis in reset", ss_discharge, 1'b0);
        check1("R1 fl in reset", force_low, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R1 hiz after reset", gate_hiz, 1'b0);
        check1("R1 dis after reset", ss_discharge, 1'b0);
        en_in = 1'b1;
        repeat (2) @(negedge clk);

        // R3: pulse termination active before the ramp is done
        ss_done = 1'b0; oc_flag = 1'b1;
        #1 check1("R3 pulse_cut during soft-start", pulse_cut, 1'b1);
        oc_flag = 1'b0;
        #1 check1("R3 pulse_cut clean", pulse_cut, 1'b0);

        // R2 / R3: 32 current strobes with ss_done low latches at the 32nd
        for (int i = 1; i <= 32; i++)
            period(1, 0, 0, 0, (i == 32), 0, 0, "R2 oc streak");
        oc_flag = 1'b1;
        #1 check1("R3 pulse_cut off when latched", pulse_cut, 1'b0);
        oc_flag = 1'b0;
        // R4: latched state persists
        for (int i = 0; i < 5; i++) period(0, 0, 0, 1, 1, 0, 0, "R4 latch holds");
        restart();
        period(0, 0, 0, 1, 0, 0, 0, "R4 enable restart");

        // R9: a broken streak does not latch
        for (int i = 0; i < 31; i++) period(1, 0, 0, 1, 0, 0, 0, "R9 first run");
        period(0, 0, 0, 1, 0, 0, 0, "R9 clean strobe");
        for (int i = 0; i < 31; i++) period(1, 0, 0, 1, 0, 0, 0, "R9 second run");
        period(1, 0, 0, 1, 1, 0, 0, "R2 32nd consecutive");

        // R4: supply drop also releases
        @(negedge clk); por_ok = 1'b0;
        @(negedge clk); por_ok = 1'b1;
        @(negedge clk);
        period(0, 0, 0, 1, 0, 0, 0, "R4 supply restart");

        // R10: flags between strobes ignored
        noise = 1'b1;
        for (int i = 0; i < 40; i++) period(0, 0, 0, 1, 0, 0, 0, "R10 off-strobe flags");
        noise = 1'b0;
        @(negedge clk);

        // R5: low-output hiccup
        for (int i = 1; i <= 8; i++) period(0, 1, 0, 1, 0, (i == 8), 0, "R5 uv streak");
        for (int i = 1; i <= 4; i++) period(0, 0, 0, 0, 0, (i < 4), 0, "R5 discharge");
        for (int i = 1; i <= 7; i++) period(0, 1, 0, 1, 0, 0, 0, "R5 count restarted");
        period(0, 0, 0, 1, 0, 0, 0, "R9 uv clean");

        // R12: flags during discharge not counted
        for (int i = 1; i <= 8; i++) period(0, 1, 0, 1, 0, (i == 8), 0, "R12 enter hiccup");
        for (int i = 1; i <= 4; i++) period(1, 0, 0, 0, 0, (i < 4), 0, "R12 oc in discharge");
        for (int i = 1; i <= 31; i++) period(1, 0, 0, 1, 0, 0, 0, "R12 fresh oc count");
        period(1, 0, 0, 1, 1, 0, 0, "R12 latch at 32");
        restart();

        // R6: high output ignored before the ramp is done
        for (int i = 0; i < 40; i++) period(0, 0, 1, 0, 0, 0, 0, "R6 ov unarmed");
        // R7: low-side hold follows the armed flag
        period(0, 0, 1, 1, 0, 0, 1, "R7 ov armed");
        period(0, 0, 0, 1, 0, 0, 0, "R7 ov cleared");
        // R8: 32 armed high-output strobes latch
        for (int i = 1; i <= 32; i++)
            period(0, 0, 1, 1, (i == 32), 0, (i < 32), "R8 ov streak");
        restart();

        // R11: current shutdown and low-output restart due together
        for (int i = 1; i <= 24; i++) period(1, 0, 0, 1, 0, 0, 0, "R11 oc lead");
        for (int i = 1; i <= 8; i++)
            period(1, 1, 0, 1, (i == 8), 0, 0, "R11 both complete");
        restart();
        period(0, 0, 0, 1, 0, 0, 0, "R4 final restart");

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule